// File: doc/BRIEF.md
# Port Pin Interrupt Event Controller

This block turns pin activity and an internal timer event into latched interrupt requests and picks the most urgent one. Four single pins each raise their own interrupt on a falling edge. An eight-bit port raises a shared group interrupt, but only when the whole port leaves the all-high state. A one-cycle underflow pulse from the converter timer raises the most urgent interrupt of all. The pins are sampled the same way whether the surrounding logic uses them as inputs or drives them as outputs, so driving one of them low acts as a software-triggered interrupt.

Each event sets a pending flag. The flag stays set until the matching acknowledge bit clears it. A priority encoder reports the lowest-numbered pending interrupt whose enable bit is set. Every external pin passes through a two-stage synchronizer before any edge is detected. The timer pulse is already synchronous, so it enters the pending register directly.

Interrupt numbering: the converter timer is index 0, single pins 0..3 are indices 3, 4, 6 and 7, and the port group is index 5. Indices 1 and 2 have no source inside this block.

Top module: `portIrqController`

## Requirements
- R1: A high-to-low change on single pin p (p = 0..3) sets pending bit 3, 4, 6 or 7 respectively, three clock edges after the pin changes.
- R2: A low-to-high change on a single pin sets no pending bit.
- R3: When the port changes from all ones (0xFF) to any other value, pending bit 5 is set.
- R4: While any port pin stays low, further high-to-low changes on other port pins do not set pending bit 5.
- R5: The group detector re-arms only after all eight port pins read high again; a later exit from 0xFF then sets bit 5 again.
- R6: The group detector starts disarmed after reset and arms only once the synchronized port reads 0xFF.
- R7: A one-cycle timer underflow pulse sets pending bit 0 on the next clock edge.
- R8: A pending bit stays set until its acknowledge bit is high on a clock edge, which clears it.
- R9: If a bit's event and its acknowledge arrive on the same edge, the bit stays set.
- R10: irqValid is high exactly when some pending bit has its enable set. irqIndex is then the lowest such index.
- R11: Enable bits affect selection only: a pending bit with its enable clear stays latched and is not chosen.
- R12: While reset is asserted, all pending bits and irqValid are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 4 | Single interrupt pins, raw levels |
| grpIn | input | GRP_W | Group port, raw levels |
| tmrUnderflow | input | 1 | Synchronous one-cycle timer underflow pulse |
| irqEnable | input | 8 | Per-interrupt enable for selection |
| irqAck | input | 8 | Per-interrupt clear |
| irqPending | output | 8 | Latched pending flags |
| irqValid | output | 1 | An enabled interrupt is pending |
| irqIndex | output | 3 | Lowest enabled pending index |

## Verification
The bench builds the block with its defaults: an eight-pin group port and two synchronizer stages. With these values, the three-edge pin latency and the exact 0xFF arming condition can be observed directly. A behavioural model tracks the same delays and compares the pending flags, valid and index on every cycle. Directed phases drive the port through partial lows, re-arming and a disarmed start after reset. They also cover rising pin edges, an event and its acknowledge on the same edge, and masking by the enable bits.

// File: rtl/irqEvtPkg.sv
package irqEvtPkg;
  localparam int IRQ_COUNT = 8;
  localparam int IRQ_IDX_W = $clog2(IRQ_COUNT);
  localparam int PIN_COUNT = 4;
  localparam int TIMER_IRQ = 0;
  localparam int GROUP_IRQ = 5;

  typedef logic [IRQ_COUNT-1:0] irqVec_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic                 tmrEvt;
    logic                 grpEvt;
    logic [PIN_COUNT-1:0] pinEvt;
  } evtStrobe_t;

  // Map a single pin to its interrupt index
  function automatic logic [IRQ_IDX_W-1:0] pinIrq(input int p);
    case (p)
      0:       return IRQ_IDX_W'(3);
      1:       return IRQ_IDX_W'(4);
      2:       return IRQ_IDX_W'(6);
      default: return IRQ_IDX_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[0] <= '0;
          else       stg[0] <= d;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[i] <= '0;
          else       stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/irqEvtCtrl.sv
module irqEvtCtrl
  import irqEvtPkg::*;
#(
  parameter int GRP_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [GRP_W-1:0]     grpIn,
  input  logic                 tmrUnderflow,
  output evtStrobe_t           strobe
);
  logic [PIN_COUNT-1:0] pinSync, pinPrev;
  logic [GRP_W-1:0]     grpSync;
  logic                 armed, grpAllHigh, grpFire;

  syncChain #(.W(PIN_COUNT), .DEPTH(SYNC_DEPTH)) uPinSync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(pinSync));

  syncChain #(.W(GRP_W), .DEPTH(SYNC_DEPTH)) uGrpSync (
    .clk(clk), .rstN(rstN), .d(grpIn), .q(grpSync));

  // Previous level starts low, so no false fall right after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign grpAllHigh = &grpSync;
  assign grpFire    = armed & ~grpAllHigh;

  // Arm on all-high, disarm on firing; starts disarmed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           armed <= 1'b0;
    else if (grpAllHigh) armed <= 1'b1;
    else if (grpFire)    armed <= 1'b0;
  end

  always_comb begin
    strobe.pinEvt = pinPrev & ~pinSync;
    strobe.grpEvt = grpFire;
    strobe.tmrEvt = tmrUnderflow;
  end

  // R3: the group only fires right after an all-high sample
  assert_fire_after_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    grpFire |-> $past(grpAllHigh));

  // R4: one exit yields one strobe; no repeat until re-armed
  assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rstN)
    grpFire |=> !grpFire);

  // R5: an all-high sample always leaves the detector armed
  assert_rearm_R5: assert property (@(posedge clk) disable iff (!rstN)
    grpAllHigh |=> armed);
endmodule

// File: rtl/irqEvtDatapath.sv
module irqEvtDatapath
  import irqEvtPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  evtStrobe_t           strobe,
  input  irqVec_t              irqAck,
  input  irqVec_t              irqEnable,
  output irqVec_t              irqPending,
  output logic                 irqValid,
  output logic [IRQ_IDX_W-1:0] irqIndex
);
  irqVec_t raise, pendQ, cand;

  always_comb begin
    raise            = '0;
    raise[TIMER_IRQ] = strobe.tmrEvt;
    raise[GROUP_IRQ] = strobe.grpEvt;
    for (int p = 0; p < PIN_COUNT; p++)
      if (strobe.pinEvt[p]) raise[pinIrq(p)] = 1'b1;
  end

  // Event wins over acknowledge on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~irqAck) | raise;
  end

  assign cand = pendQ & irqEnable;

  always_comb begin
    irqIndex = '0;
    for (int i = IRQ_COUNT - 1; i >= 0; i--)
      if (cand[i]) irqIndex = IRQ_IDX_W'(i);
  end

  assign irqValid   = |cand;
  assign irqPending = pendQ;

  // R8: unacknowledged flags never drop
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ & ~irqAck) & ~pendQ) == '0));

  // R8: flags only appear with an event
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendQ & ~$past(pendQ) & ~$past(raise)) == '0));

  // R9: an event always lands, acknowledged or not
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(raise) & ~pendQ) == '0));

  // R7: timer pulse is visible one edge later
  assert_timer_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tmrEvt |=> pendQ[TIMER_IRQ]);

  // R10: chosen index is enabled, pending and lowest
  assert_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (pendQ[irqIndex] && irqEnable[irqIndex] &&
                  ((cand & ((irqVec_t'(1) << irqIndex) - irqVec_t'(1))) == '0)));
endmodule

// File: rtl/portIrqController.sv
module portIrqController
  import irqEvtPkg::*;
#(
  parameter int GRP_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [GRP_W-1:0]     grpIn,
  input  logic                 tmrUnderflow,
  input  logic [IRQ_COUNT-1:0] irqEnable,
  input  logic [IRQ_COUNT-1:0] irqAck,
  output logic [IRQ_COUNT-1:0] irqPending,
  output logic                 irqValid,
  output logic [IRQ_IDX_W-1:0] irqIndex
);
  evtStrobe_t strobe;

  irqEvtCtrl #(.GRP_W(GRP_W), .SYNC_DEPTH(SYNC_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .grpIn(grpIn),
    .tmrUnderflow(tmrUnderflow), .strobe(strobe));

  irqEvtDatapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqAck(irqAck),
    .irqEnable(irqEnable), .irqPending(irqPending),
    .irqValid(irqValid), .irqIndex(irqIndex));

  // R12: nothing pending while held in reset
  assert_reset_R12: assert property (@(posedge clk)
    !rstN |-> (irqPending == '0 && !irqValid));
endmodule

// File: tb/sim_portIrqController.sv
`timescale 1ns/1ps
module sim_portIrqController;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pins;
  logic [7:0] grp, en, ack, pending;
  logic       tmr, valid;
  logic [2:0] index;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  portIrqController u0 (
    .clk(clk), .rstN(rstN), .pinIn(pins), .grpIn(grp),
    .tmrUnderflow(tmr), .irqEnable(en), .irqAck(ack),
    .irqPending(pending), .irqValid(valid), .irqIndex(index));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: delay lines as queues, event rules as written
  logic [3:0] pinLine[$];
  logic [7:0] grpLine[$];
  logic [3:0] lastPin;
  logic       mArmed;
  logic [7:0] mPend;
  int         pinMap[4] = '{3, 4, 6, 7};

  always @(posedge clk) begin
    logic [7:0] rz;
    logic [3:0] curPin;
    logic [7:0] curGrp;
    if (!rstN) begin
      pinLine = '{4'h0, 4'h0};
      grpLine = '{8'h0, 8'h0};
      lastPin = 4'h0;
      mArmed  = 1'b0;
      mPend   = 8'h0;
    end else begin
      curPin = pinLine[$];
      curGrp = grpLine[$];
      rz = 8'h0;
      if (tmr) rz[0] = 1'b1;
      if (mArmed && curGrp != 8'hFF) rz[5] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (lastPin[p] && !curPin[p]) rz[pinMap[p]] = 1'b1;
      if (curGrp == 8'hFF) mArmed = 1'b1;
      else if (rz[5])      mArmed = 1'b0;
      mPend   = (mPend & ~ack) | rz;
      lastPin = curPin;
      pinLine.push_front(pins);
      void'(pinLine.pop_back());
      grpLine.push_front(grp);
      void'(grpLine.pop_back());
    end
  end

  always @(negedge clk) begin
    #1;
    begin
      logic [7:0] c;
      int lowest;
      c = mPend & en;
      lowest = 0;
      for (int i = 7; i >= 0; i--) if (c[i]) lowest = i;
      chk("R8 model pending", 32'(pending), 32'(mPend));
      chk("R10 model valid", 32'(valid), 32'(c != 8'h0));
      if (c != 8'h0) chk("R10 model index", 32'(index), 32'(lowest));
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    pins = 4'hF; grp = 8'h7F; tmr = 1'b0; ack = 8'h0; en = 8'h0;
    waitN(3); #1;
    chk("R12 pending in reset", 32'(pending), 32'h0);
    chk("R12 valid in reset", 32'(valid), 32'h0);
    waitN(1); rstN = 1'b1;
    waitN(6); #1;
    chk("R6 no event after reset", 32'(pending), 32'h0);
    waitN(1); grp = 8'h3F;
    waitN(5); #1;
    chk("R6 disarmed start", 32'(pending), 32'h0);
    waitN(1); grp = 8'hFF;
    waitN(4); grp = 8'hFE;
    waitN(5); #1;
    chk("R3 exit from all ones", 32'(pending), 32'h20);
    waitN(1); ack = 8'h20;
    waitN(1); ack = 8'h0;
    waitN(1); #1;
    chk("R8 ack clears", 32'(pending), 32'h0);
    waitN(1); grp = 8'hFC;
    waitN(2); grp = 8'hFE;
    waitN(2); grp = 8'hFC;
    waitN(2); grp = 8'hF0;
    waitN(5); #1;
    chk("R4 partial lows ignored", 32'(pending), 32'h0);
    waitN(1); grp = 8'hFF;
    waitN(4); grp = 8'hEF;
    waitN(5); #1;
    chk("R5 re-armed fire", 32'(pending), 32'h20);
    waitN(1); ack = 8'hFF;
    waitN(1); ack = 8'h0; pins = 4'hE;
    waitN(5); #1;
    chk("R1 pin0 fall", 32'(pending), 32'h08);
    waitN(1); pins = 4'hF;
    waitN(5); #1;
    chk("R2 rise ignored", 32'(pending), 32'h08);
    waitN(1); ack = 8'hFF;
    waitN(1); ack = 8'h0; pins = 4'h0;
    waitN(5); #1;
    chk("R1 all pins fall", 32'(pending), 32'hD8);
    waitN(1); en = 8'hFF; #1;
    chk("R10 valid", 32'(valid), 32'h1);
    chk("R10 lowest index", 32'(index), 32'h3);
    waitN(1); en = 8'hC0; #1;
    chk("R11 masked skip", 32'(index), 32'h6);
    waitN(1); en = 8'h00; #1;
    chk("R11 none enabled", 32'(valid), 32'h0);
    chk("R11 still latched", 32'(pending), 32'hD8);
    waitN(1); tmr = 1'b1;
    waitN(1); tmr = 1'b0; #1;
    chk("R7 timer pending", 32'(pending), 32'hD9);
    waitN(1); en = 8'hFF; #1;
    chk("R10 timer first", 32'(index), 32'h0);
    waitN(1); ack = 8'h01; tmr = 1'b1;
    waitN(1); ack = 8'h0; tmr = 1'b0; #1;
    chk("R9 set beats ack", 32'(pending), 32'hD9);
    waitN(1); ack = 8'h01;
    waitN(1); ack = 8'h0; #1;
    chk("R8 single ack", 32'(pending), 32'hD8);
    chk("R10 next index", 32'(index), 32'h3);
    waitN(1); ack = 8'hFF;
    waitN(1); ack = 8'h0; #1;
    chk("R8 all cleared", 32'(pending), 32'h0);
    chk("R10 idle", 32'(valid), 32'h0);
    waitN(3);
    summary();
    $finish;
  end
endmodule